// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits between a processor's 16-bit memory bus and three memory devices: a 256-byte boot ROM, a cartridge port and an internal RAM. For each processor access it works out which device owns the address. It then raises that device's select and hands the device its local address and write data. On a read it returns the device's byte to the processor. A read of an address that no device provides returns an all-ones byte.

After reset the boot ROM covers the bottom 256 addresses, so the processor's first fetch from address zero returns boot ROM byte 0. Boot code ends its work by writing the value 1 to a control address. From then on the bottom 256 addresses belong to the cartridge like the rest of the low half of the address space. Nothing on the bus can bring the boot ROM back. Only a reset restores it.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the overlay is active: a read of address 0x0000 selects the boot ROM with local address 0 and returns the boot ROM's byte.
- R2: While the overlay is active, a read of 0x0000–0x00FF raises only `romSel`, drives `romAddr` with the low 8 address bits and returns `romRdata` on `cpuRdata` in the same cycle.
- R3: An access to 0x0100–0x7FFF raises only `cartSel` whatever the overlay state, drives `cartAddr` with address bits 14:0, and raises `cartWr` with `cartWdata` equal to `cpuWdata` on a write. A read returns `cartRdata`.
- R4: A write of exactly 0x01 to 0xFF50 disables the overlay from the following clock edge. After that, every access to 0x0000–0x00FF goes to the cartridge as in R3, including writes.
- R5: Once disabled, the overlay stays disabled under any later bus write, including writes to 0xFF50. Only an active-low reset re-enables it.
- R6: A write to 0xFF50 with any value other than 0x01 leaves the overlay state unchanged.
- R7: An access to 0xC000–0xDFFF raises only `ramSel`, drives `ramAddr` with address bits 12:0, and raises `ramWr` with `ramWdata` equal to `cpuWdata` on a write. A read returns `ramRdata`.
- R8: A read of 0x8000–0xBFFF, 0xE000–0xFF4F or 0xFF51–0xFFFF raises no select and returns 0xFF.
- R9: While the overlay is active, a write to 0x0000–0x00FF raises no select, and neither `cartWr` nor `ramWr` is raised.
- R10: At most one select is high in any cycle. No select is high when neither `cpuRd` nor `cpuWr` is high. A read of a device address raises exactly one select.
- R11: A read of 0xFF50 raises no select and returns 0xFE while the overlay is active and 0xFF once it is disabled (bit 0 set means disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, restores the overlay |
| cpuAddr | input | 16 | Processor address |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe |
| cpuWdata | input | 8 | Processor write data |
| cpuRdata | output | 8 | Read data returned to the processor |
| romSel | output | 1 | Boot ROM select |
| romAddr | output | 8 | Boot ROM local address |
| romRdata | input | 8 | Boot ROM read data |
| cartSel | output | 1 | Cartridge select |
| cartWr | output | 1 | Cartridge write strobe |
| cartAddr | output | 15 | Cartridge local address |
| cartWdata | output | 8 | Cartridge write data |
| cartRdata | input | 8 | Cartridge read data |
| ramSel | output | 1 | Internal RAM select |
| ramWr | output | 1 | Internal RAM write strobe |
| ramAddr | output | 13 | Internal RAM local address |
| ramWdata | output | 8 | Internal RAM write data |
| ramRdata | input | 8 | Internal RAM read data |

## Verification
The overlay latch is the only state in the block. If it is wrong, the first access to the bottom 256 addresses shows it: the select goes to the wrong device and returns the wrong byte, in the same cycle the access is made. The control address also shows it, through bit 0 of the byte read back. The bench therefore follows each control write with reads of the low window and of the control address in the next cycles. It also probes non-matching values, repeated writes after the disable, and a reset pulse, so a latch that clears, sets too easily or ignores reset is caught within one or two accesses. Decode faults show up as a wrong select or a wrong read byte on the same cycle.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // which target owns the current access
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_ROM  = 3'd1,
    RGN_CART = 3'd2,
    RGN_RAM  = 3'd3,
    RGN_CTRL = 3'd4
  } rgnT;

  // strobes from control to datapath
  typedef struct packed {
    rgnT  rgn;
    logic rdEn;
    logic wrEn;
    logic ovlOff;
  } strobeT;

endpackage

// File: rtl/boot_ovl_ctrl.sv
module boot_ovl_ctrl
  import boot_ovl_pkg::*;
#(
  parameter int ROM_BYTES = 256,
  parameter int CART_BYTES = 32768,
  parameter int RAM_BASE = 'hC000,
  parameter int RAM_BYTES = 8192,
  parameter int CTRL_ADDR = 'hFF50,
  parameter int DIS_VAL = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWdata,
  output strobeT            strobe
);

  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] ROM_END  = CW'(ROM_BYTES);
  localparam logic [CW-1:0] CART_END = CW'(CART_BYTES);
  localparam logic [CW-1:0] RAM_LO   = CW'(RAM_BASE);
  localparam logic [CW-1:0] RAM_HI   = CW'(RAM_BASE + RAM_BYTES);
  localparam logic [CW-1:0] CTRL_AD  = CW'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] DIS_CODE = DATA_W'(DIS_VAL);

  logic [CW-1:0] wideAddr;
  logic inRom, inCart, inRam, isCtrl, access;
  logic ovlOff;
  rgnT  rgn;

  assign wideAddr = {1'b0, cpuAddr};
  assign inRom  = wideAddr < ROM_END;
  assign inCart = wideAddr < CART_END;
  assign inRam  = (wideAddr >= RAM_LO) && (wideAddr < RAM_HI);
  assign isCtrl = wideAddr == CTRL_AD;
  assign access = cpuRd | cpuWr;

  // one-shot overlay disable; cleared only by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlOff <= 1'b0;
    end else if (cpuWr && isCtrl && (cpuWdata == DIS_CODE)) begin
      ovlOff <= 1'b1;
    end
  end

  always_comb begin
    rgn = RGN_NONE;
    if (!access) begin
      rgn = RGN_NONE;
    end else if (inRom && !ovlOff) begin
      // read-only window: writes are dropped here
      rgn = cpuWr ? RGN_NONE : RGN_ROM;
    end else if (inCart) begin
      rgn = RGN_CART;
    end else if (inRam) begin
      rgn = RGN_RAM;
    end else if (isCtrl) begin
      rgn = RGN_CTRL;
    end
  end

  assign strobe.rgn    = rgn;
  assign strobe.rdEn   = cpuRd & ~cpuWr;
  assign strobe.wrEn   = cpuWr;
  assign strobe.ovlOff = ovlOff;

endmodule

// File: rtl/boot_ovl_datapath.sv
module boot_ovl_datapath
  import boot_ovl_pkg::*;
#(
  parameter int ROM_AW = 8,
  parameter int CART_AW = 15,
  parameter int RAM_AW = 13
) (
  input  strobeT             strobe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               romSel,
  output logic [ROM_AW-1:0]  romAddr,
  input  logic [DATA_W-1:0]  romRdata,
  output logic               cartSel,
  output logic               cartWr,
  output logic [CART_AW-1:0] cartAddr,
  output logic [DATA_W-1:0]  cartWdata,
  input  logic [DATA_W-1:0]  cartRdata,
  output logic               ramSel,
  output logic               ramWr,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [DATA_W-1:0]  ramWdata,
  input  logic [DATA_W-1:0]  ramRdata
);

  localparam logic [DATA_W-1:0] FILL = '1;

  assign romSel  = strobe.rgn == RGN_ROM;
  assign cartSel = strobe.rgn == RGN_CART;
  assign ramSel  = strobe.rgn == RGN_RAM;
  assign cartWr  = cartSel & strobe.wrEn;
  assign ramWr   = ramSel & strobe.wrEn;

  assign romAddr   = cpuAddr[ROM_AW-1:0];
  assign cartAddr  = cpuAddr[CART_AW-1:0];
  assign ramAddr   = cpuAddr[RAM_AW-1:0];
  assign cartWdata = cpuWdata;
  assign ramWdata  = cpuWdata;

  always_comb begin
    unique case (strobe.rgn)
      RGN_ROM:  cpuRdata = romRdata;
      RGN_CART: cpuRdata = cartRdata;
      RGN_RAM:  cpuRdata = ramRdata;
      RGN_CTRL: cpuRdata = {FILL[DATA_W-1:1], strobe.ovlOff};
      default:  cpuRdata = FILL;
    endcase
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_ovl_pkg::*;
#(
  parameter int ROM_BYTES = 256,
  parameter int CART_BYTES = 32768,
  parameter int RAM_BASE = 'hC000,
  parameter int RAM_BYTES = 8192,
  parameter int CTRL_ADDR = 'hFF50,
  parameter int DIS_VAL = 1,
  localparam int ROM_AW = $clog2(ROM_BYTES),
  localparam int CART_AW = $clog2(CART_BYTES),
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        cpuAddr,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  output logic               romSel,
  output logic [ROM_AW-1:0]  romAddr,
  input  logic [7:0]         romRdata,
  output logic               cartSel,
  output logic               cartWr,
  output logic [CART_AW-1:0] cartAddr,
  output logic [7:0]         cartWdata,
  input  logic [7:0]         cartRdata,
  output logic               ramSel,
  output logic               ramWr,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [7:0]         ramWdata,
  input  logic [7:0]         ramRdata
);

  strobeT strobe;

  boot_ovl_ctrl #(
    .ROM_BYTES(ROM_BYTES), .CART_BYTES(CART_BYTES), .RAM_BASE(RAM_BASE),
    .RAM_BYTES(RAM_BYTES), .CTRL_ADDR(CTRL_ADDR), .DIS_VAL(DIS_VAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuWdata(cpuWdata), .strobe(strobe)
  );

  boot_ovl_datapath #(
    .ROM_AW(ROM_AW), .CART_AW(CART_AW), .RAM_AW(RAM_AW)
  ) uPath (
    .strobe(strobe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .romSel(romSel), .romAddr(romAddr), .romRdata(romRdata),
    .cartSel(cartSel), .cartWr(cartWr), .cartAddr(cartAddr),
    .cartWdata(cartWdata), .cartRdata(cartRdata),
    .ramSel(ramSel), .ramWr(ramWr), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

endmodule

// File: rtl/boot_ovl_checker.sv
module boot_ovl_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic [7:0]  cpuWdata,
  input logic [7:0]  cpuRdata,
  input logic        romSel,
  input logic        cartSel,
  input logic        cartWr,
  input logic        ramSel,
  input logic        ramWr
);

  // independent record of whether the disable write has been seen
  logic seenOff;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenOff <= 1'b0;
    else if (cpuWr && cpuAddr == 16'hFF50 && cpuWdata == 8'h01) seenOff <= 1'b1;
  end

  logic lowWin, unmapped;
  assign lowWin = cpuAddr < 16'h0100;
  assign unmapped = (cpuAddr >= 16'h8000 && cpuAddr < 16'hC000) ||
                    (cpuAddr >= 16'hE000 && cpuAddr != 16'hFF50);

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, cartSel, ramSel}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRd || cpuWr) |-> !(romSel || cartSel || ramSel));

  assert_rom_while_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && lowWin && !seenOff) |-> romSel);

  assert_cart_after_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd || cpuWr) && lowWin && seenOff) |-> (cartSel && !romSel));

  assert_rom_gone_R5: assert property (@(posedge clk) disable iff (!rstN)
    seenOff |-> !romSel);

  assert_rom_write_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && lowWin && !seenOff) |-> !(romSel || cartSel || cartWr || ramWr));

  assert_unmapped_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && unmapped) |-> (cpuRdata == 8'hFF && !(romSel || cartSel || ramSel)));

  assert_ram_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd || cpuWr) && cpuAddr >= 16'hC000 && cpuAddr < 16'hE000) |-> ramSel);

  assert_ctrl_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && cpuAddr == 16'hFF50) |-> (cpuRdata == {7'h7F, seenOff}));

endmodule

bind boot_overlay_decoder boot_ovl_checker uChk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .romSel(romSel), .cartSel(cartSel),
  .cartWr(cartWr), .ramSel(ramSel), .ramWr(ramWr)
);

// File: tb/tb_boot_overlay_decoder.sv
`timescale 1ns/1ps
module tb_boot_overlay_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata, romRdata, cartRdata, ramRdata, cartWdata, ramWdata;
  logic romSel, cartSel, cartWr, ramSel, ramWr;
  logic [7:0] romAddr;
  logic [14:0] cartAddr;
  logic [12:0] ramAddr;

  int nChecks = 0;
  int nFails = 0;
  bit modelOff = 1'b0;

  always #10 clk = ~clk;

  // device models: data derived from the local address each device receives
  assign romRdata  = romAddr ^ 8'hA5;
  assign cartRdata = cartAddr[7:0] + 8'h3C;
  assign ramRdata  = ramAddr[7:0] ^ 8'h5A;

  boot_overlay_decoder dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .romSel(romSel), .romAddr(romAddr), .romRdata(romRdata),
    .cartSel(cartSel), .cartWr(cartWr), .cartAddr(cartAddr),
    .cartWdata(cartWdata), .cartRdata(cartRdata),
    .ramSel(ramSel), .ramWr(ramWr), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h addr=%04h", req, what, act, exp, cpuAddr);
    end
  endtask

  // behavioural reference for the current bus cycle
  task automatic compareAll(string req);
    bit acc, eRom, eCart, eRam;
    int eData;
    acc = cpuRd || cpuWr;
    eRom = 0; eCart = 0; eRam = 0; eData = 'hFF;
    if (acc) begin
      if (cpuAddr < 16'h0100 && !modelOff) begin
        eRom = !cpuWr;
        eData = (cpuAddr[7:0] ^ 8'hA5);
      end else if (cpuAddr < 16'h8000) begin
        eCart = 1;
        eData = 8'(cpuAddr[7:0] + 8'h3C);
      end else if (cpuAddr >= 16'hC000 && cpuAddr < 16'hE000) begin
        eRam = 1;
        eData = (cpuAddr[7:0] ^ 8'h5A);
      end else if (cpuAddr == 16'hFF50) begin
        eData = modelOff ? 'hFF : 'hFE;
      end
    end
    check(req, "romSel", romSel, eRom);
    check(req, "cartSel", cartSel, eCart);
    check(req, "ramSel", ramSel, eRam);
    check(req, "cartWr", cartWr, eCart && cpuWr);
    check(req, "ramWr", ramWr, eRam && cpuWr);
    if (cpuRd && !cpuWr) check(req, "cpuRdata", cpuRdata, eData);
    if (eRom) check(req, "romAddr", romAddr, cpuAddr[7:0]);
    if (eCart) check(req, "cartAddr", cartAddr, cpuAddr[14:0]);
    if (eRam) check(req, "ramAddr", ramAddr, cpuAddr[12:0]);
    if (eCart && cpuWr) check(req, "cartWdata", cartWdata, cpuWdata);
    if (eRam && cpuWr) check(req, "ramWdata", ramWdata, cpuWdata);
  endtask

  task automatic step(string req, logic [15:0] a, logic rd, logic wr, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWdata = d;
    #2;
    compareAll(req);
    @(posedge clk);
    #1;
    if (wr && a == 16'hFF50 && d == 8'h01) modelOff = 1'b1;
  endtask

  task automatic pulseReset();
    @(negedge clk);
    cpuRd = 0; cpuWr = 0; rstN = 0;
    @(posedge clk);
    #1 modelOff = 1'b0;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    fork
      begin
        #(200000 * 20);
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    step("R1", 16'h0000, 1, 0, 8'h00);
    step("R2", 16'h007F, 1, 0, 8'h00);
    step("R2", 16'h00FF, 1, 0, 8'h00);
    step("R3", 16'h0100, 1, 0, 8'h00);
    step("R3", 16'h4321, 1, 0, 8'h00);
    step("R3", 16'h7FFF, 1, 0, 8'h00);
    step("R3", 16'h2000, 0, 1, 8'h9C);
    step("R7", 16'hC000, 1, 0, 8'h00);
    step("R7", 16'hDFFF, 1, 0, 8'h00);
    step("R7", 16'hD123, 0, 1, 8'h47);
    step("R8", 16'h8000, 1, 0, 8'h00);
    step("R8", 16'hBFFF, 1, 0, 8'h00);
    step("R8", 16'hE000, 1, 0, 8'h00);
    step("R8", 16'hFF4F, 1, 0, 8'h00);
    step("R8", 16'hFF51, 1, 0, 8'h00);
    step("R8", 16'hFFFF, 1, 0, 8'h00);
    step("R10", 16'h0040, 0, 0, 8'h00);
    step("R10", 16'hC010, 0, 0, 8'h00);
    step("R9", 16'h0010, 0, 1, 8'h33);
    step("R9", 16'h00FF, 0, 1, 8'h01);
    step("R11", 16'hFF50, 1, 0, 8'h00);
    step("R6", 16'hFF50, 0, 1, 8'h00);
    step("R6", 16'hFF50, 0, 1, 8'h02);
    step("R6", 16'hFF50, 0, 1, 8'hFF);
    step("R6", 16'hFF50, 0, 1, 8'h81);
    step("R6", 16'h0000, 1, 0, 8'h00);
    step("R6", 16'hFF50, 1, 0, 8'h00);
    step("R4", 16'hFF50, 0, 1, 8'h01);
    step("R4", 16'h0000, 1, 0, 8'h00);
    step("R4", 16'h00FF, 1, 0, 8'h00);
    step("R4", 16'h0010, 0, 1, 8'h6E);
    step("R11", 16'hFF50, 1, 0, 8'h00);
    step("R5", 16'hFF50, 0, 1, 8'h00);
    step("R5", 16'hFF50, 0, 1, 8'hFE);
    step("R5", 16'h0001, 1, 0, 8'h00);
    step("R5", 16'hFF50, 1, 0, 8'h00);
    step("R10", 16'h0080, 0, 0, 8'h00);
    pulseReset();
    step("R5", 16'h0000, 1, 0, 8'h00);
    step("R5", 16'hFF50, 1, 0, 8'h00);
    step("R1", 16'h0042, 1, 0, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule